// File: doc/BRIEF.md
# Grouped Four-Level Interrupt Priority Controller

This block sits beside an 8-bit microcontroller core and decides which of eleven interrupt sources the core services next. The sources are paired into six priority groups. Each group takes a 2-bit level from two priority registers: one register supplies the high bit of every group and the other supplies the low bit. Hardware latches every request in a flag. A flag competes only when its own enable bit and the global enable are set. The winner is the pending source with the highest level. When levels tie, a fixed polling order decides.

The block presents a registered valid signal and a 4-bit vector index. Both hold steady until the core acknowledges. An acknowledge clears the serviced flag and marks its level as in service. While a level is in service, only a strictly higher level can interrupt it. A return-from-interrupt pulse retires the highest level in service. The last source carries a nested sub-source with its own enable and a sticky sub-flag that only software can clear. A small write/read port gives software access to the enable, priority and sub-source bits.

Top module: `grp_irq_prio`

## Requirements
- R1: After reset all register fields, all flags and the in-service mask are zero, `irq_valid_o` is low and every register reads 0.
- R2: Register map, 8-bit data. Address 0 holds source enables 7..0 in bits 7:0. Address 1 holds the global enable (bit 7), the sub-flag (bit 4), the sub-enable (bit 3) and source enables 10..8 (bits 2:0). Address 2 holds the low priority bit of groups 5..0 (bits 5:0) and a stored spare bit (bit 6). Address 3 holds the high priority bit of groups 5..0 (bits 5:0). Bits not listed read 0.
- R3: Source s belongs to group s/2, and its level is {address 3 bit g, address 2 bit g} (00 lowest, 11 highest). The highest pending level wins. Bit 6 of address 2 has no effect on arbitration.
- R4: Among pending sources at the same level, the lowest source index wins. The vector index equals the source index (0..10).
- R5: A source competes only when its enable bit and the global enable are both 1. A flag latched while disabled is taken once it is enabled.
- R6: `irq_valid_o` and `irq_vec_o` come from registers. They rise one clock after the flag is set and hold unchanged until acknowledge, even if a higher request arrives.
- R7: `ack_i` while valid clears the served flag, sets the in-service bit of its level and drops valid on the next clock. `ack_i` while valid is low has no effect.
- R8: While any level is in service, only a request whose level is strictly higher than the highest level in service is presented.
- R9: `reti_i` clears the highest set bit of the in-service mask.
- R10: Source 10 requests when its flag or (sub-flag AND sub-enable) is set, gated like every other source. `sub_irq_i` sets the sub-flag. Acknowledge does not clear the sub-flag. Writing address 1 with bit 4 = 0 clears it, and writing bit 4 = 1 does not set it.
- R11: A request that arrives in the same cycle as the acknowledge of the same source leaves its flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 11 | Request pulses, one per source |
| sub_irq_i | input | 1 | Request pulse of the nested sub-source |
| ack_i | input | 1 | Core accepts the presented vector |
| reti_i | input | 1 | Core returns from the current handler |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| irq_valid_o | output | 1 | A vector is presented |
| irq_vec_o | output | 4 | Index of the presented source |

## Verification
Two functions can fall in the same cycle. An acknowledge may clear a source's flag while a new request for that same source tries to set it. A return from interrupt may retire a level while another request at that level is waiting. The bench raises a request pulse on the very cycle it asserts the acknowledge, then checks that the same vector is presented again after the return. It also stacks two levels, retires them one at a time, and checks that the waiting equal-level request appears only after the last return and one clock of arbitration.

// File: rtl/grp_irq_prio_pkg.sv
package grp_irq_prio_pkg;
   localparam int ADDR_W       = 2;
   localparam logic [ADDR_W-1:0] A_EN_LO   = 2'd0;
   localparam logic [ADDR_W-1:0] A_EN_HI   = 2'd1;
   localparam logic [ADDR_W-1:0] A_PRIO_LO = 2'd2;
   localparam logic [ADDR_W-1:0] A_PRIO_HI = 2'd3;
   localparam int SUB_EN_BIT   = 3;
   localparam int SUB_FLAG_BIT = 4;
   localparam int LVL_W        = 2;
   typedef logic [LVL_W-1:0] lvl_t;

   function automatic int grp_of(input int src);
      return src / 2;
   endfunction
endpackage

// File: rtl/ipc_regs.sv
module ipc_regs
   import grp_irq_prio_pkg::*;
#(
   parameter int N_SRC  = 11,
   parameter int N_GRP  = 6,
   parameter int DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o,
   input  logic              sub_set_i,
   output logic [N_SRC-1:0]  src_en_o,
   output logic              glob_en_o,
   output logic              sub_en_o,
   output logic              sub_flag_o,
   output logic [N_GRP-1:0]  prio_lo_o,
   output logic [N_GRP-1:0]  prio_hi_o
);
   localparam int HI_EN_W = N_SRC - DATA_W;
   localparam int SPARE_BIT = N_GRP;

   if (HI_EN_W < 1 || HI_EN_W > SUB_EN_BIT) begin : g_bad_en
      $error("ipc_regs: upper enable field must hold 1..3 sources");
   end
   if (SPARE_BIT >= DATA_W - 1) begin : g_bad_grp
      $error("ipc_regs: priority fields do not fit the data width");
   end

   logic [DATA_W-1:0]  en_lo_q;
   logic [HI_EN_W-1:0] en_hi_q;
   logic               gen_q, sub_en_q, sub_flag_q, spare_q;
   logic [N_GRP-1:0]   plo_q, phi_q;

   logic wr_lo, wr_hi, wr_plo, wr_phi, sub_clr;
   assign wr_lo   = wr_en_i && (wr_addr_i == A_EN_LO);
   assign wr_hi   = wr_en_i && (wr_addr_i == A_EN_HI);
   assign wr_plo  = wr_en_i && (wr_addr_i == A_PRIO_LO);
   assign wr_phi  = wr_en_i && (wr_addr_i == A_PRIO_HI);
   assign sub_clr = wr_hi && !wr_data_i[SUB_FLAG_BIT];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_lo_q    <= '0;
         en_hi_q    <= '0;
         gen_q      <= 1'b0;
         sub_en_q   <= 1'b0;
         sub_flag_q <= 1'b0;
         spare_q    <= 1'b0;
         plo_q      <= '0;
         phi_q      <= '0;
      end else begin
         if (wr_lo) en_lo_q <= wr_data_i;
         if (wr_hi) begin
            en_hi_q  <= wr_data_i[HI_EN_W-1:0];
            sub_en_q <= wr_data_i[SUB_EN_BIT];
            gen_q    <= wr_data_i[DATA_W-1];
         end
         if (wr_plo) begin
            plo_q   <= wr_data_i[N_GRP-1:0];
            spare_q <= wr_data_i[SPARE_BIT];
         end
         if (wr_phi) phi_q <= wr_data_i[N_GRP-1:0];
         // hardware set wins over a software clear in the same cycle
         sub_flag_q <= sub_set_i | (sub_flag_q & ~sub_clr);
      end
   end

   always_comb begin
      rd_data_o = '0;
      unique case (rd_addr_i)
         A_EN_LO: rd_data_o = en_lo_q;
         A_EN_HI: begin
            rd_data_o[HI_EN_W-1:0]  = en_hi_q;
            rd_data_o[SUB_EN_BIT]   = sub_en_q;
            rd_data_o[SUB_FLAG_BIT] = sub_flag_q;
            rd_data_o[DATA_W-1]     = gen_q;
         end
         A_PRIO_LO: begin
            rd_data_o[N_GRP-1:0] = plo_q;
            rd_data_o[SPARE_BIT] = spare_q;
         end
         default: rd_data_o[N_GRP-1:0] = phi_q;
      endcase
   end

   assign src_en_o   = {en_hi_q, en_lo_q};
   assign glob_en_o  = gen_q;
   assign sub_en_o   = sub_en_q;
   assign sub_flag_o = sub_flag_q;
   assign prio_lo_o  = plo_q;
   assign prio_hi_o  = phi_q;

   AST_SUBFLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sub_flag_q && !sub_clr |=> sub_flag_q); // R10
   AST_SUBFLAG_NOSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sub_flag_q && !sub_set_i |=> !sub_flag_q); // R10
endmodule

// File: rtl/ipc_flags.sv
module ipc_flags #(
   parameter int N_SRC = 11
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [N_SRC-1:0] set_i,
   input  logic [N_SRC-1:0] clr_i,
   output logic [N_SRC-1:0] flag_o
);
   for (genvar s = 0; s < N_SRC; s++) begin : g_flag
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) q <= 1'b0;
         else         q <= set_i[s] | (q & ~clr_i[s]);
      end
      assign flag_o[s] = q;
   end

   AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      |set_i |=> ((flag_o & $past(set_i)) == $past(set_i))); // R11
endmodule

// File: rtl/ipc_insvc.sv
module ipc_insvc
   import grp_irq_prio_pkg::*;
#(
   parameter int N_LVL = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             push_i,
   input  lvl_t             lvl_i,
   input  logic             pop_i,
   output logic [N_LVL-1:0] mask_o,
   output logic             busy_o,
   output lvl_t             top_o
);
   logic [N_LVL-1:0] mask_q, pop_bit, push_bit;
   lvl_t             top;

   always_comb begin
      top = '0;
      for (int j = 0; j < N_LVL; j++) begin
         if (mask_q[j]) top = lvl_t'(j);
      end
   end

   assign pop_bit  = (pop_i && |mask_q) ? (N_LVL'(1) << top) : '0;
   assign push_bit = push_i ? (N_LVL'(1) << lvl_i) : '0;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mask_q <= '0;
      else         mask_q <= (mask_q & ~pop_bit) | push_bit;
   end

   assign mask_o = mask_q;
   assign busy_o = |mask_q;
   assign top_o  = top;

   AST_RETI_POPS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pop_i && !push_i && (mask_q != '0)
      |=> $countones(mask_q) == $countones($past(mask_q)) - 1); // R9
   AST_RETI_KEEPS_LOWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pop_i && !push_i |=> (mask_q | ($past(mask_q) & ~mask_q)) == $past(mask_q)); // R9
endmodule

// File: rtl/ipc_arbiter.sv
module ipc_arbiter
   import grp_irq_prio_pkg::*;
#(
   parameter int N_SRC = 11,
   parameter int N_GRP = 6,
   parameter int VEC_W = 4
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic [N_SRC-1:0]      pend_i,
   input  logic [N_GRP-1:0][1:0] grp_lvl_i,
   input  logic                  busy_i,
   input  lvl_t                  top_i,
   input  logic                  ack_i,
   output logic                  valid_o,
   output logic [VEC_W-1:0]      vec_o,
   output lvl_t                  lvl_o
);
   logic             found;
   lvl_t             best_lvl;
   logic [VEC_W-1:0] best_idx;
   logic             cand_ok;

   // scan in polling order; strict compare keeps the earlier source on a tie
   always_comb begin
      found    = 1'b0;
      best_lvl = '0;
      best_idx = '0;
      for (int s = 0; s < N_SRC; s++) begin
         if (pend_i[s] && (!found || grp_lvl_i[grp_of(s)] > best_lvl)) begin
            found    = 1'b1;
            best_lvl = grp_lvl_i[grp_of(s)];
            best_idx = VEC_W'(s);
         end
      end
   end

   assign cand_ok = found && (!busy_i || best_lvl > top_i);

   logic             valid_q;
   logic [VEC_W-1:0] vec_q;
   lvl_t             lvl_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         valid_q <= 1'b0;
         vec_q   <= '0;
         lvl_q   <= '0;
      end else if (valid_q) begin
         if (ack_i) valid_q <= 1'b0;
      end else begin
         valid_q <= cand_ok;
         vec_q   <= best_idx;
         lvl_q   <= best_lvl;
      end
   end

   assign valid_o = valid_q;
   assign vec_o   = vec_q;
   assign lvl_o   = lvl_q;

   AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_q && !ack_i |=> valid_q && $stable(vec_q)); // R6
   AST_ACK_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_q && ack_i |=> !valid_q); // R7
   AST_VEC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_q |-> vec_q < VEC_W'(N_SRC)); // R4
endmodule

// File: rtl/grp_irq_prio.sv
module grp_irq_prio
   import grp_irq_prio_pkg::*;
#(
   parameter int N_SRC  = 11,
   parameter int N_GRP  = 6,
   parameter int N_LVL  = 4,
   parameter int DATA_W = 8,
   parameter int VEC_W  = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [N_SRC-1:0]  irq_i,
   input  logic              sub_irq_i,
   input  logic              ack_i,
   input  logic              reti_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              irq_valid_o,
   output logic [VEC_W-1:0]  irq_vec_o
);
   localparam int LAST = N_SRC - 1;

   if (N_LVL != (1 << LVL_W)) begin : g_bad_lvl
      $error("grp_irq_prio: two priority bits give exactly four levels");
   end
   if (N_SRC > 2 * N_GRP || N_SRC <= 2 * (N_GRP - 1)) begin : g_bad_pair
      $error("grp_irq_prio: sources must fill the groups two by two");
   end
   if ((1 << VEC_W) < N_SRC) begin : g_bad_vec
      $error("grp_irq_prio: vector index too narrow");
   end

   logic [N_SRC-1:0]      src_en, flag, clr, pend;
   logic                  glob_en, sub_en, sub_flag;
   logic [N_GRP-1:0]      plo, phi;
   logic [N_GRP-1:0][1:0] grp_lvl;
   logic [N_LVL-1:0]      insvc;
   logic                  busy, ack_take;
   lvl_t                  top_lvl, cur_lvl;

   ipc_regs #(.N_SRC(N_SRC), .N_GRP(N_GRP), .DATA_W(DATA_W)) i_regs (
      .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i, .rd_data_o,
      .sub_set_i (sub_irq_i),
      .src_en_o  (src_en),
      .glob_en_o (glob_en),
      .sub_en_o  (sub_en),
      .sub_flag_o(sub_flag),
      .prio_lo_o (plo),
      .prio_hi_o (phi)
   );

   ipc_flags #(.N_SRC(N_SRC)) i_flags (
      .clk_i, .rst_ni,
      .set_i (irq_i),
      .clr_i (clr),
      .flag_o(flag)
   );

   assign ack_take = ack_i && irq_valid_o;

   for (genvar g = 0; g < N_GRP; g++) begin : g_lvl
      assign grp_lvl[g] = {phi[g], plo[g]};
   end

   for (genvar s = 0; s < N_SRC; s++) begin : g_src
      assign clr[s] = ack_take && (irq_vec_o == VEC_W'(s));
      if (s == LAST) begin : g_nested
         assign pend[s] = (flag[s] | (sub_flag & sub_en)) & src_en[s] & glob_en;
      end else begin : g_plain
         assign pend[s] = flag[s] & src_en[s] & glob_en;
      end
   end

   ipc_insvc #(.N_LVL(N_LVL)) i_insvc (
      .clk_i, .rst_ni,
      .push_i(ack_take),
      .lvl_i (cur_lvl),
      .pop_i (reti_i),
      .mask_o(insvc),
      .busy_o(busy),
      .top_o (top_lvl)
   );

   ipc_arbiter #(.N_SRC(N_SRC), .N_GRP(N_GRP), .VEC_W(VEC_W)) i_arb (
      .clk_i, .rst_ni,
      .pend_i   (pend),
      .grp_lvl_i(grp_lvl),
      .busy_i   (busy),
      .top_i    (top_lvl),
      .ack_i    (ack_i),
      .valid_o  (irq_valid_o),
      .vec_o    (irq_vec_o),
      .lvl_o    (cur_lvl)
   );

   AST_NEST_ABOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_valid_o && busy |-> cur_lvl > top_lvl); // R8
   AST_STRAY_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_i && !irq_valid_o && !reti_i |=> insvc == $past(insvc)); // R7
   AST_ACK_MARKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_take && !reti_i |=> insvc[$past(cur_lvl)]); // R7
endmodule

// File: tb/test_grp_irq_prio.sv
module test_grp_irq_prio;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [10:0] irq = '0;
   logic        sub_irq = 1'b0, ack = 1'b0, reti = 1'b0, wr_en = 1'b0;
   logic [1:0]  wr_addr = '0, rd_addr = '0;
   logic [7:0]  wr_data = '0, rd_data;
   logic        valid;
   logic [3:0]  vec;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   grp_irq_prio i_grp_irq_prio (
      .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .sub_irq_i(sub_irq),
      .ack_i(ack), .reti_i(reti), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
      .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
      .irq_valid_o(valid), .irq_vec_o(vec)
   );

   // {prio_lo[6:0], prio_hi[5:0], request mask[10:0], expected vector[3:0]}
   localparam logic [27:0] VECS [8] = '{
      {7'b0000000, 6'b000000, 11'b00000001010, 4'd1},
      {7'b0000100, 6'b000000, 11'b00000010001, 4'd4},
      {7'b0000001, 6'b100000, 11'b10100000001, 4'd10},
      {7'b0001000, 6'b001010, 11'b00010000100, 4'd7},
      {7'b0000000, 6'b000000, 11'b01100000000, 4'd8},
      {7'b1000000, 6'b000000, 11'b00001100000, 4'd5},
      {7'b0000011, 6'b000001, 11'b00000001010, 4'd1},
      {7'b0100000, 6'b000000, 11'b10000000001, 4'd10}
   };

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic pulse(input logic [10:0] m);
      irq = m;
      tick();
      irq = '0;
   endtask

   task automatic do_ack();
      ack = 1'b1; tick(); ack = 1'b0;
   endtask

   task automatic do_reti();
      reti = 1'b1; tick(); reti = 1'b0;
   endtask

   task automatic drain();
      repeat (8) begin
         tick();
         if (valid) begin
            do_ack();
            do_reti();
         end
      end
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] d;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R1 reset state
      chk("R1 valid", int'(valid), 0);
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), d);
         chk("R1 reg", int'(d), 0);
      end

      // R2 register map readback
      wr(2'd0, 8'hA5); rd(2'd0, d); chk("R2 en_lo", int'(d), 'hA5);
      wr(2'd1, 8'hFF); rd(2'd1, d); chk("R2 en_hi", int'(d), 'h8F);
      wr(2'd2, 8'hFF); rd(2'd2, d); chk("R2 prio_lo", int'(d), 'h7F);
      wr(2'd3, 8'hFF); rd(2'd3, d); chk("R2 prio_hi", int'(d), 'h3F);
      wr(2'd0, 8'hFF); wr(2'd1, 8'h87); wr(2'd2, 8'h00); wr(2'd3, 8'h00);
      rd(2'd1, d); chk("R2 en_hi restore", int'(d), 'h87);

      // R3 R4 vector table: level first, then polling order
      for (int k = 0; k < 8; k++) begin
         logic [27:0] e;
         e = VECS[k];
         wr(2'd2, {1'b0, e[27:21]});
         wr(2'd3, {2'b00, e[20:15]});
         pulse(e[14:4]);
         tick();
         chk("R3 R4 valid", int'(valid), 1);
         chk("R3 R4 vector", int'(vec), int'(e[3:0]));
         drain();
      end
      wr(2'd2, 8'h00); wr(2'd3, 8'h00);

      // R5 global enable and source enable
      wr(2'd1, 8'h07);
      pulse(11'h001); tick(); tick();
      chk("R5 global off", int'(valid), 0);
      wr(2'd1, 8'h87); tick();
      chk("R5 global on", int'(valid), 1);
      chk("R5 global on vec", int'(vec), 0);
      drain();
      wr(2'd0, 8'hFE);
      pulse(11'h001); tick(); tick();
      chk("R5 source off", int'(valid), 0);
      wr(2'd0, 8'hFF); tick();
      chk("R5 source on vec", int'(vec), 0);
      drain();

      // R6 registered output and hold until acknowledge
      wr(2'd2, 8'h20); wr(2'd3, 8'h20);
      pulse(11'h001);
      chk("R6 not yet", int'(valid), 0);
      tick();
      chk("R6 one clock later", int'(valid), 1);
      pulse(11'h400); tick(); tick();
      chk("R6 held vec", int'(vec), 0);
      do_ack();
      chk("R7 ack drops valid", int'(valid), 0);
      tick();
      chk("R6 higher follows", int'(vec), 10);
      do_ack(); do_reti(); do_reti();
      drain();
      wr(2'd2, 8'h00); wr(2'd3, 8'h00);

      // R7 stray acknowledge leaves in-service mask alone
      tick();
      do_ack();
      pulse(11'h001); tick();
      chk("R7 stray ack ignored", int'(valid), 1);
      do_ack();
      do_reti(); tick(); tick();
      chk("R7 flag cleared", int'(valid), 0);

      // R8 R9 nesting: g0 level 1, g1 level 2, g2 level 0
      wr(2'd2, 8'h01); wr(2'd3, 8'h02);
      pulse(11'h001); tick();
      chk("R8 first vec", int'(vec), 0);
      do_ack();
      pulse(11'h002); tick(); tick();
      chk("R8 equal level waits", int'(valid), 0);
      pulse(11'h010); tick(); tick();
      chk("R8 lower level waits", int'(valid), 0);
      pulse(11'h004); tick();
      chk("R8 higher nests", int'(valid), 1);
      chk("R8 higher vec", int'(vec), 2);
      do_ack();
      do_reti(); tick();
      chk("R9 level 1 still busy", int'(valid), 0);
      do_reti(); tick();
      chk("R9 equal request after pop", int'(vec), 1);
      chk("R9 equal request valid", int'(valid), 1);
      do_ack(); do_reti(); tick();
      chk("R9 lowest last", int'(vec), 4);
      drain();
      wr(2'd2, 8'h00); wr(2'd3, 8'h00);

      // R10 nested sub-source with sticky flag
      wr(2'd1, 8'h8F);
      sub_irq = 1'b1; tick(); sub_irq = 1'b0;
      tick();
      chk("R10 sub request vec", int'(vec), 10);
      rd(2'd1, d); chk("R10 sub flag set", int'(d), 'h9F);
      do_ack(); do_reti(); tick();
      chk("R10 sticky re-request", int'(valid), 1);
      wr(2'd1, 8'h8F);
      rd(2'd1, d); chk("R10 software clear", int'(d), 'h8F);
      do_ack(); do_reti(); tick(); tick();
      chk("R10 quiet after clear", int'(valid), 0);
      wr(2'd1, 8'h9F);
      rd(2'd1, d); chk("R10 write one no set", int'(d), 'h8F);
      wr(2'd1, 8'h87);

      // R11 new request collides with acknowledge
      pulse(11'h008); tick();
      chk("R11 presented", int'(vec), 3);
      ack = 1'b1; irq = 11'h008; tick(); ack = 1'b0; irq = '0;
      chk("R11 ack drops", int'(valid), 0);
      do_reti(); tick();
      chk("R11 request kept", int'(valid), 1);
      chk("R11 request kept vec", int'(vec), 3);
      drain();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule